// File: doc/BRIEF.md
# Pulse-Induction Timing Sequencer

This block produces every timing line of a pulse-induction transmit/receive front end from one system clock. A phase counter runs through a repetition period whose length is set at runtime in clock cycles. Inside each period the block raises a transmit level, a boost level at the front of the transmit pulse, a damping level after transmit-off, a receiver-unblock level, three one-cycle sample strobes, and a blanking window. While the blanking window is high, the boost-regulator enable is pulled low.

The period length, transmit width, boost width and damp width arrive as plain input words. The block copies them into shadow registers only when a new period begins, so the software side can write them at any time. The three strobe offsets are set in microseconds as parameters and are converted to cycle counts through a clock-frequency parameter. The blanking length is a parameter percentage of the programmed period. An edge or strobe that would fall past the end of the period is pulled back to the period end, and a flag output reports this for that period.

Top module: `pi_pulse_sequencer`

## Requirements
- R1: The pattern repeats every P cycles, where P is the latched period value. A period value of 0 acts as 1. Phase 0 is the first cycle of each period.
- R2: The period and width inputs are copied only on the edge that starts a new period. A change to the inputs in the middle of a period has no effect on any output until the next period begins.
- R3: `tx_o` is high during phases 0 to T-1. `damp_o` is high from phase T for D cycles. The two are never high together.
- R4: `boost_o` is high during phases 0 to K-1, measured from the start of the transmit pulse.
- R5: `rx_en_o` is high from the end of damping (phase T+D) until the period ends.
- R6: Each strobe is high for exactly one phase. `smp_o[0]` fires at T+D+S0_US*CLK_MHZ. `smp_o[1]` fires at T+S1_US*CLK_MHZ. `smp_o[2]` fires at T+(S1_US+S2_GAP_US)*CLK_MHZ.
- R7: `blank_o` is high from phase T for floor(P*BLANK_PCT/100) cycles. `reg_en_o` is low exactly while `blank_o` is high, and high at all other times.
- R8: A window end beyond P is cut to P. A strobe phase at or beyond P fires on phase P-1 instead. `clamp_o` is high for the whole period whenever any such cut applies to that period's values.
- R9: While the synchronous reset `rst` is high, all outputs are low except `reg_en_o`, which is high. The first period starts on the first edge after `rst` falls, using the input values at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| period_i | input | CNT_W | Repetition period in cycles |
| tx_w_i | input | CNT_W | Transmit width in cycles |
| boost_w_i | input | CNT_W | Boost width in cycles |
| damp_w_i | input | CNT_W | Damp width in cycles |
| tx_o | output | 1 | Transmit drive level |
| boost_o | output | 1 | Boost drive level |
| damp_o | output | 1 | Damping drive level |
| rx_en_o | output | 1 | Receiver unblock level |
| smp_o | output | 3 | Sample strobes; bit 0 is S0, bit 1 is S1, bit 2 is S2 |
| blank_o | output | 1 | Regulator blanking window |
| reg_en_o | output | 1 | Boost-regulator enable |
| clamp_o | output | 1 | Some edge of the current period was cut to the period end |

## Verification
Two strobes can land on the same phase. S0 follows the damp end, while S1 follows transmit-off. When D+S0 offset equals the S1 offset, both bits of `smp_o` must rise in the same cycle, and a directed case sets the damp width to produce exactly this. A second overlap happens when a clamped strobe lands on the last phase of the period, in the same cycle as the period wrap and the reload of new inputs. Directed cases with the S2 phase equal to P, and with inputs changed in mid-period, are checked cycle by cycle against a phase model in the bench. The same model judges the random configurations.

// File: rtl/pis_pkg.sv
package pis_pkg;
   localparam int SMP_N  = 3;
   localparam int SMP_S0 = 0;
   localparam int SMP_S1 = 1;
   localparam int SMP_S2 = 2;

   // lesser of a window end and its limit
   function automatic logic [31:0] sat32(input logic [31:0] a, input logic [31:0] lim);
      return (a > lim) ? lim : a;
   endfunction
endpackage

// File: rtl/pis_cfg_latch.sv
module pis_cfg_latch #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] period_i,
   input  logic [CNT_W-1:0] tx_w_i,
   input  logic [CNT_W-1:0] boost_w_i,
   input  logic [CNT_W-1:0] damp_w_i,
   output logic [CNT_W-1:0] cp,
   output logic [CNT_W-1:0] ct,
   output logic [CNT_W-1:0] ck,
   output logic [CNT_W-1:0] cd
);
   always_ff @(posedge clk) begin
      if (rst) begin
         cp <= '0;
         ct <= '0;
         ck <= '0;
         cd <= '0;
      end else if (load) begin
         cp <= period_i;
         ct <= tx_w_i;
         ck <= boost_w_i;
         cd <= damp_w_i;
      end
   end
endmodule

// File: rtl/pis_phase_cnt.sv
module pis_phase_cnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] plast,
   output logic [CNT_W-1:0] ph,
   output logic             run,
   output logic             load
);
   assign load = !run || (ph == plast);

   always_ff @(posedge clk) begin
      if (rst) begin
         ph  <= '0;
         run <= 1'b0;
      end else if (load) begin
         ph  <= '0;
         run <= 1'b1;
      end else begin
         ph  <= ph + 1'b1;
      end
   end

   // R1: phase never passes the last phase of the latched period
   a_r1_phase_bound: assert property (@(posedge clk) disable iff (rst)
      run |-> (ph <= plast));
endmodule

// File: rtl/pis_event_map.sv
module pis_event_map
   import pis_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int CLK_MHZ    = 125,
   parameter int S0_US      = 2,
   parameter int S1_US      = 15,
   parameter int S2_GAP_US  = 30,
   parameter int BLANK_PCT  = 20
) (
   input  logic [CNT_W-1:0]            cp,
   input  logic [CNT_W-1:0]            ct,
   input  logic [CNT_W-1:0]            ck,
   input  logic [CNT_W-1:0]            cd,
   output logic [CNT_W-1:0]            p_len,
   output logic [31:0]                 e_tx,
   output logic [31:0]                 e_boost,
   output logic [31:0]                 e_damp,
   output logic [31:0]                 e_blank,
   output logic [SMP_N-1:0][31:0]      smp_pos,
   output logic                        clamp
);
   localparam logic [31:0] C0 = 32'(S0_US * CLK_MHZ);
   localparam logic [31:0] C1 = 32'(S1_US * CLK_MHZ);
   localparam logic [31:0] C2 = 32'((S1_US + S2_GAP_US) * CLK_MHZ);

   logic [31:0] p32, t32, k32, d32, td32, blen, bl_raw;
   logic [SMP_N-1:0] smp_over;

   assign p_len  = (cp == '0) ? CNT_W'(1) : cp;
   assign p32    = 32'(p_len);
   assign t32    = 32'(ct);
   assign k32    = 32'(ck);
   assign d32    = 32'(cd);
   assign td32   = t32 + d32;
   assign blen   = (p32 * 32'(BLANK_PCT)) / 32'd100;
   assign bl_raw = t32 + blen;

   assign e_tx    = sat32(t32, p32);
   assign e_boost = sat32(k32, p32);
   assign e_damp  = sat32(td32, p32);
   assign e_blank = sat32(bl_raw, p32);

   for (genvar i = 0; i < SMP_N; i++) begin : g_smp
      localparam logic [31:0] OFS = (i == SMP_S0) ? C0 : (i == SMP_S1) ? C1 : C2;
      logic [31:0] raw;
      assign raw         = ((i == SMP_S0) ? td32 : t32) + OFS;
      assign smp_over[i] = (raw >= p32);
      assign smp_pos[i]  = smp_over[i] ? (p32 - 32'd1) : raw;
   end

   assign clamp = (t32 > p32) || (k32 > p32) || (td32 > p32) ||
                  (bl_raw > p32) || (|smp_over);
endmodule

// File: rtl/pi_pulse_sequencer.sv
module pi_pulse_sequencer
   import pis_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int CLK_MHZ   = 125,
   parameter int S0_US     = 2,
   parameter int S1_US     = 15,
   parameter int S2_GAP_US = 30,
   parameter int BLANK_PCT = 20
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] period_i,
   input  logic [CNT_W-1:0] tx_w_i,
   input  logic [CNT_W-1:0] boost_w_i,
   input  logic [CNT_W-1:0] damp_w_i,
   output logic             tx_o,
   output logic             boost_o,
   output logic             damp_o,
   output logic             rx_en_o,
   output logic [2:0]       smp_o,
   output logic             blank_o,
   output logic             reg_en_o,
   output logic             clamp_o
);
   if (CNT_W < 4 || CNT_W > 24) begin : g_bad_w
      $error("CNT_W must lie in 4..24");
   end
   if (BLANK_PCT < 0 || BLANK_PCT > 100) begin : g_bad_pct
      $error("BLANK_PCT must lie in 0..100");
   end
   if (CLK_MHZ < 1 || (S1_US + S2_GAP_US) * CLK_MHZ >= (1 << CNT_W)) begin : g_bad_ofs
      $error("strobe offsets do not fit CNT_W");
   end
   if (S0_US < 0 || S1_US < 0 || S2_GAP_US < 0) begin : g_bad_us
      $error("strobe offsets must be non-negative");
   end

   logic [CNT_W-1:0] cp, ct, ck, cd, p_len, plast, ph;
   logic             run, load, clamp;
   logic [31:0]      e_tx, e_boost, e_damp, e_blank, ph32;
   logic [SMP_N-1:0][31:0] smp_pos;

   pis_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .plast(plast), .ph(ph), .run(run), .load(load)
   );

   pis_cfg_latch #(.CNT_W(CNT_W)) u_cfg (
      .clk(clk), .rst(rst), .load(load),
      .period_i(period_i), .tx_w_i(tx_w_i), .boost_w_i(boost_w_i), .damp_w_i(damp_w_i),
      .cp(cp), .ct(ct), .ck(ck), .cd(cd)
   );

   pis_event_map #(
      .CNT_W(CNT_W), .CLK_MHZ(CLK_MHZ), .S0_US(S0_US), .S1_US(S1_US),
      .S2_GAP_US(S2_GAP_US), .BLANK_PCT(BLANK_PCT)
   ) u_map (
      .cp(cp), .ct(ct), .ck(ck), .cd(cd), .p_len(p_len),
      .e_tx(e_tx), .e_boost(e_boost), .e_damp(e_damp), .e_blank(e_blank),
      .smp_pos(smp_pos), .clamp(clamp)
   );

   assign plast = p_len - {{(CNT_W-1){1'b0}}, 1'b1};
   assign ph32  = 32'(ph);

   assign tx_o     = run && (ph32 < e_tx);
   assign boost_o  = run && (ph32 < e_boost);
   assign damp_o   = run && (ph32 >= e_tx) && (ph32 < e_damp);
   assign rx_en_o  = run && (ph32 >= e_damp);
   assign blank_o  = run && (ph32 >= e_tx) && (ph32 < e_blank);
   assign reg_en_o = !blank_o;
   assign clamp_o  = run && clamp;

   for (genvar i = 0; i < SMP_N; i++) begin : g_strobe
      assign smp_o[i] = run && (ph32 == smp_pos[i]);
   end

   // R3: transmit and damping never overlap
   a_r3_tx_damp_excl: assert property (@(posedge clk) disable iff (rst)
      !(tx_o && damp_o));

   // R2: latched values hold for the whole period
   a_r2_cfg_hold: assert property (@(posedge clk) disable iff (rst)
      (run && ph != '0) |-> ($stable(cp) && $stable(ct) && $stable(ck) && $stable(cd)));

   // R6: an unclamped strobe never falls inside the transmit pulse
   a_r6_strobe_after_tx: assert property (@(posedge clk) disable iff (rst)
      ((|smp_o) && !clamp_o) |-> !tx_o);

   // R5: receiver unblocks only once transmit and damping are over
   a_r5_rx_after_damp: assert property (@(posedge clk) disable iff (rst)
      $rose(rx_en_o) |-> (!tx_o && !damp_o));

   // R9: reset state on the edge after reset is sampled
   a_r9_reset_state: assert property (@(posedge clk)
      rst |=> (!tx_o && !boost_o && !damp_o && !rx_en_o && smp_o == 3'b000 &&
               !blank_o && reg_en_o && !clamp_o));
endmodule

// File: tb/pi_pulse_sequencer_test.sv
module pi_pulse_sequencer_test;
   localparam int CNT_W   = 16;
   localparam int CLK_MHZ = 2;
   localparam int OF0 = 2 * CLK_MHZ;
   localparam int OF1 = 15 * CLK_MHZ;
   localparam int OF2 = 45 * CLK_MHZ;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst;
   logic [CNT_W-1:0] period_i, tx_w_i, boost_w_i, damp_w_i;
   logic tx_o, boost_o, damp_o, rx_en_o, blank_o, reg_en_o, clamp_o;
   logic [2:0] smp_o;

   pi_pulse_sequencer #(.CNT_W(CNT_W), .CLK_MHZ(CLK_MHZ)) uut (
      .clk(clk), .rst(rst), .period_i(period_i), .tx_w_i(tx_w_i),
      .boost_w_i(boost_w_i), .damp_w_i(damp_w_i), .tx_o(tx_o), .boost_o(boost_o),
      .damp_o(damp_o), .rx_en_o(rx_en_o), .smp_o(smp_o), .blank_o(blank_o),
      .reg_en_o(reg_en_o), .clamp_o(clamp_o)
   );

   int n_chk = 0, n_err = 0;
   int mrun = 0, mph = 0, mP = 0, mT = 0, mK = 0, mD = 0;
   int mid_pending = 0;
   bit done = 0;

   function automatic int imin(int a, int b);
      return (a < b) ? a : b;
   endfunction

   task automatic chk(string what, int got, int exp);
      n_chk++;
      if (got != exp) begin
         n_err++;
         $display("FAIL %s phase %0d: got %0d expected %0d", what, mph, got, exp);
      end
   endtask

   function automatic int plen();
      return (mP == 0) ? 1 : mP;
   endfunction

   task automatic compare();
      int p, etx, ebo, eda, ebl, s0, s1, s2, cl;
      bit ebk;
      p   = plen();
      etx = imin(mT, p);
      ebo = imin(mK, p);
      eda = imin(mT + mD, p);
      ebl = imin(mT + (p * 20) / 100, p);
      s0  = imin(mT + mD + OF0, p - 1);
      s1  = imin(mT + OF1, p - 1);
      s2  = imin(mT + OF2, p - 1);
      cl  = (mT > p || mK > p || mT + mD > p || mT + mD + OF0 >= p ||
             mT + OF1 >= p || mT + OF2 >= p || mT + (p * 20) / 100 > p) ? 1 : 0;
      ebk = (mph >= etx) && (mph < ebl);
      if (mph == 0) chk("R1 tx at period start", int'(tx_o), (etx > 0) ? 1 : 0);
      chk("R3 tx", int'(tx_o), (mph < etx) ? 1 : 0);
      chk("R3 damp", int'(damp_o), (mph >= etx && mph < eda) ? 1 : 0);
      chk("R4 boost", int'(boost_o), (mph < ebo) ? 1 : 0);
      chk("R5 rx_en", int'(rx_en_o), (mph >= eda) ? 1 : 0);
      chk("R6 s0", int'(smp_o[0]), (mph == s0) ? 1 : 0);
      chk("R6 s1", int'(smp_o[1]), (mph == s1) ? 1 : 0);
      chk("R6 s2", int'(smp_o[2]), (mph == s2) ? 1 : 0);
      chk("R7 blank", int'(blank_o), ebk ? 1 : 0);
      chk("R7 reg_en", int'(reg_en_o), ebk ? 0 : 1);
      chk("R8 clamp", int'(clamp_o), cl);
      if (mid_pending != 0)
         chk("R2 old values kept", int'({tx_o, damp_o, blank_o}),
             int'({mph < etx, mph >= etx && mph < eda, ebk}));
   endtask

   // one clock of the phase model, then sample away from the edge
   task automatic step();
      @(posedge clk);
      if (mrun == 0 || mph == plen() - 1) begin
         mrun = 1; mph = 0; mid_pending = 0;
         mP = int'(period_i); mT = int'(tx_w_i); mK = int'(boost_w_i); mD = int'(damp_w_i);
      end else begin
         mph++;
      end
      @(negedge clk);
      compare();
   endtask

   task automatic set_cfg(int p, int t, int k, int d);
      period_i  = CNT_W'(p);
      tx_w_i    = CNT_W'(t);
      boost_w_i = CNT_W'(k);
      damp_w_i  = CNT_W'(d);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      // R9: outputs during reset
      chk("R9 reset tx", int'(tx_o), 0);
      chk("R9 reset strobes", int'(smp_o), 0);
      chk("R9 reset others", int'({boost_o, damp_o, rx_en_o, blank_o, clamp_o}), 0);
      chk("R9 reset reg_en", int'(reg_en_o), 1);
      rst = 1'b0;
      mrun = 0;
      mid_pending = 0;
   endtask

   task automatic run_cycles(int n);
      for (int i = 0; i < n; i++) step();
   endtask

   initial begin
      rst = 1'b1;
      set_cfg(200, 20, 8, 10);
      do_reset();
      run_cycles(420);                 // basic pattern, two periods
      set_cfg(200, 15, 6, OF1 - OF0);  // S0 and S1 on the same phase
      do_reset();
      run_cycles(410);
      set_cfg(100, 50, 120, 20);       // boost and S2 cut, R8
      do_reset();
      run_cycles(220);
      set_cfg(140, 50, 10, 5);         // S2 lands exactly on P
      do_reset();
      run_cycles(300);
      set_cfg(0, 0, 0, 0);             // R1 zero period acts as one
      do_reset();
      run_cycles(6);
      set_cfg(150, 30, 12, 10);        // R2 mid-period change
      do_reset();
      run_cycles(50);
      set_cfg(80, 10, 4, 6);
      mid_pending = 1;
      run_cycles(100 + 170);
      process::self().srandom(32'd7);
      for (int c = 0; c < 30; c++) begin
         int p;
         p = 1 + int'($urandom % 300);
         set_cfg(p, int'($urandom % (p + 20)), int'($urandom % (p + 10)), int'($urandom % 60));
         mid_pending = (mrun != 0 && mph != plen() - 1) ? 1 : 0;
         run_cycles(int'($urandom % 250) + 2 * p);
      end
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end
endmodule